// File: doc/BRIEF.md
# Multiplexed External Bus Strobe Sequencer

This block turns a single core-side memory request into a strobe sequence on an 8-bit multiplexed external bus. The request carries a direction flag, a 16-bit address, a write byte, and a select that picks data space or program space. While the transfer runs, the upper address byte sits on a dedicated port. A second port carries the lower address byte first and the data byte after it.

An address strobe pulses low, and an external latch captures the lower byte when that strobe rises. One turnaround cycle follows, in which the address leaves the shared port. A data strobe then goes low for two clock periods, or for four when the stretch input was set at acceptance. A read byte is sampled at the rising edge of the data strobe. It is returned together with a one-cycle done pulse.

The core may offer a request whenever it likes, but the block takes one only while `req_ready` is high. All timing is in periods of `clk`, which is the internal bus clock and already runs at half the oscillator rate.

Top module: `xbus_ctrl`

## Requirements
- R1: While `rst_n` is low and after reset: `as_n`, `ds_n` and `dm_n` are 1, `bus_rd` is 1, `ad_oe` is 0, `done` is 0 and `req_ready` is 1.
- R2: A request is taken at a rising edge only when `req_valid` is 1 and `req_ready` is 1. `req_ready` is 0 from the next cycle until the transfer ends. Any `req_valid` seen while it is 0 has no effect on the outputs.
- R3: The address phase lasts two cycles after acceptance. In the first cycle `as_n` is 1, and in the second `as_n` is 0. In both cycles `ad_oe` is 1, `ad_out` equals address bits [7:0], and `addr_hi` equals address bits [15:8] for the whole transfer.
- R4: In the cycle after the address phase, both strobes are 1. For a read, `ad_oe` is 0 in that cycle.
- R5: Next, `ds_n` is 0 for DATA_CYC (2) cycles. It is 0 for DATA_CYC+STRETCH_CYC (4) cycles when `stretch_en` was 1 at acceptance. `as_n` and `ds_n` are never both 0.
- R6: For a read, `rdata` takes the value of `ad_in` at the clock edge that ends the last `ds_n`-low cycle. It holds that value until the next read completes.
- R7: For a write, `ad_oe` is 1 and `ad_out` equals the write byte from the turnaround cycle through the done cycle.
- R8: `dm_n` is 0 from the first address cycle through the done cycle when `req_data_space` was 1 at acceptance. Otherwise it is 1.
- R9: `bus_rd` (1 = read, 0 = write) holds its value from the first address cycle through the done cycle and is 1 when idle.
- R10: `done` is a one-cycle pulse in the cycle after `ds_n` rises. `req_ready` returns to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core offers a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write byte |
| req_data_space | input | 1 | 1 = data space, 0 = program space |
| stretch_en | input | 1 | Add STRETCH_CYC cycles to the data phase |
| req_ready | output | 1 | Idle; a request will be taken |
| done | output | 1 | Transfer complete pulse |
| rdata | output | 8 | Last read byte |
| addr_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Shared port, driven value |
| ad_oe | output | 1 | Shared port drive enable |
| ad_in | input | 8 | Shared port, sampled value |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| bus_rd | output | 1 | Direction, 1 = read |
| dm_n | output | 1 | Data-space select, active low |

## Verification
The bench uses the default parameters: a 16-bit address, an 8-bit data path, DATA_CYC = 2 and STRETCH_CYC = 2. Transfers are therefore 7 or 9 cycles long, so thousands of random transfers fit in the run. Requests arrive at random, including during busy cycles, and `stretch_en` changes at random during transfers. This exercises both data-phase lengths, the case where a request is held across the done cycle, and the latching of the mode at acceptance. The bus-side model drives `ad_in` only while the data strobe is low and returns a byte derived from the latched address. A read that samples at the wrong edge or with the wrong address therefore returns a wrong `rdata`.

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int DATA_CYC    = 2,
  parameter int STRETCH_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_data_space,
  input  logic              stretch_en,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic              as_n,
  output logic              ds_n,
  output logic              bus_rd,
  output logic              dm_n
);
  localparam int MAX_D = DATA_CYC + STRETCH_CYC;
  localparam int CNT_W = $clog2(MAX_D + 1);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(DATA_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_L = CNT_W'(MAX_D - 1);

  typedef enum logic [2:0] {S_IDLE, S_ASU, S_ASL, S_FLT, S_DAT, S_FIN} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic              wr_q, dsp_q, long_q;
  logic              busy, dat_last, addr_ph, wdrive;

  assign busy     = (st != S_IDLE);
  assign dat_last = (cnt == (long_q ? LAST_L : LAST_S));
  assign addr_ph  = (st == S_ASU) || (st == S_ASL);
  assign wdrive   = wr_q && ((st == S_FLT) || (st == S_DAT) || (st == S_FIN));

  assign req_ready = !busy;
  assign done      = (st == S_FIN);
  assign as_n      = (st != S_ASL);
  assign ds_n      = (st != S_DAT);
  assign bus_rd    = !(busy && wr_q);
  assign dm_n      = !(busy && dsp_q);
  assign ad_oe     = addr_ph || wdrive;
  assign ad_out    = addr_ph ? a_q[DATA_W-1:0] : wd_q;
  assign addr_hi   = a_q[ADDR_W-1:DATA_W];
  assign rdata     = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      a_q    <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      wr_q   <= 1'b0;
      dsp_q  <= 1'b0;
      long_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st     <= S_ASU;
          a_q    <= req_addr;
          wd_q   <= req_wdata;
          wr_q   <= req_write;
          dsp_q  <= req_data_space;
          long_q <= stretch_en;
        end
        S_ASU: st <= S_ASL;
        S_ASL: st <= S_FLT;
        S_FLT: begin
          st  <= S_DAT;
          cnt <= '0;
        end
        S_DAT: begin
          cnt <= cnt + 1'b1;
          if (dat_last) begin
            st <= S_FIN;
            if (!wr_q) rd_q <= ad_in;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!as_n && !ds_n));
  assert_ds_after_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ds_n) |-> $past(as_n) && $past(ds_n));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);
  assert_rw_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_n || done) |-> $stable(bus_rd));
  assert_dm_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_n || done) |-> $stable(dm_n));
  assert_take_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready && !as_n == 1'b0);
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(as_n) |-> $stable(addr_hi));
endmodule

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_write, req_data_space, stretch_en;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, rdata, ad_out, ad_in, addr_hi;
  logic req_ready, done, ad_oe, as_n, ds_n, bus_rd, dm_n;

  xbus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_data_space(req_data_space),
    .stretch_en(stretch_en), .req_ready(req_ready), .done(done), .rdata(rdata),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .as_n(as_n), .ds_n(ds_n), .bus_rd(bus_rd), .dm_n(dm_n));

  int vectors = 0, errors = 0;
  bit finished = 0;

  function automatic logic [7:0] fold(input logic [7:0] hi, input logic [7:0] lo);
    return hi ^ {lo[3:0], lo[7:4]} ^ 8'h5A;
  endfunction

  logic [7:0] slave_lo = 8'h00;
  always @(negedge clk) if (!as_n) slave_lo <= ad_out;
  assign ad_in = (!ds_n && !ad_oe) ? fold(addr_hi, slave_lo) : 8'hEE;

  int pos = -1, dlen = 2;
  logic [15:0] m_a = '0;
  logic [7:0] m_wd = '0, m_rd = '0;
  logic m_wr = 0, m_dsp = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos = -1; m_rd = '0;
    end else if (pos >= 0) begin
      if (pos == 2 + dlen && !m_wr) m_rd = fold(m_a[15:8], m_a[7:0]);
      if (pos == 3 + dlen) pos = -1; else pos++;
    end else if (req_valid) begin
      pos = 0; m_a = req_addr; m_wd = req_wdata; m_wr = req_write;
      m_dsp = req_data_space; dlen = stretch_en ? 4 : 2;
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    bit act, e_rd, e_dm, e_oe;
    string t;
    act  = pos >= 0;
    e_rd = !(act && m_wr);
    e_dm = !(act && m_dsp);
    e_oe = (pos == 0 || pos == 1) || (act && m_wr && pos >= 2);
    if (!rst_n) begin
      chk(as_n, 1, "R1"); chk(ds_n, 1, "R1"); chk(dm_n, 1, "R1");
      chk(bus_rd, 1, "R1"); chk(ad_oe, 0, "R1"); chk(done, 0, "R1");
      chk(req_ready, 1, "R1");
    end else begin
      chk(req_ready, !act, "R2");
      chk(as_n, !(pos == 1), "R3");
      chk(ds_n, !(pos >= 3 && pos < 3 + dlen), "R5");
      t = (pos == 2) ? "R4" : (pos >= 2 ? "R7" : "R3");
      chk(ad_oe, e_oe, t);
      if (e_oe) chk(ad_out, (pos < 2) ? m_a[7:0] : m_wd, (pos < 2) ? "R3" : "R7");
      if (act) chk(addr_hi, m_a[15:8], "R3");
      chk(dm_n, e_dm, "R8");
      chk(bus_rd, e_rd, "R9");
      chk(done, pos == 3 + dlen, "R10");
      chk(rdata, m_rd, "R6");
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    req_data_space = 0; stretch_en = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk); #1;
      req_valid      = ($urandom % 3) == 0;
      req_write      = $urandom % 2;
      req_addr       = 16'($urandom);
      req_wdata      = 8'($urandom);
      req_data_space = $urandom % 2;
      stretch_en     = $urandom % 2;
    end
    @(negedge clk); #1 req_valid = 0;
    repeat (12) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule